// File: doc/BRIEF.md
# Nibble-Wide Write-Only Configuration Port

This block is a serial slave that receives configuration writes four bits at a time. It has a 4-bit data bus and an active-low chip select. Inputs are sampled on the rising edge of the serial clock. The whole block runs on that clock, so the clock has to keep running for at least one edge after chip select goes high.

Each transaction opens with a 16-bit header sent as four nibbles, most significant nibble first. The header carries a read flag, a sync-request flag and a 14-bit start address. Data bytes follow, two nibbles each, high nibble first. Every finished byte leaves the block at once as a one-cycle write strobe with its address and data. The first byte goes to the start address, and each byte after it goes one address lower.

When a write transaction that asked for a sync, and wrote at least one byte, is closed by chip select rising, the block emits a one-cycle sync pulse. A busy output shows when a transaction is in progress.

Top module: `nibble_cfg_port`

## Requirements
- R1: While reset is held, and after it is released, `wr_en`, `sync_pulse` and `busy` are 0.
- R2: The header is the first four nibbles sampled with `cs_n` low, most significant first. Bit 15 is the read flag (0 means write), bit 14 is the sync request and bits 13..0 are the start address.
- R3: Each data byte is two nibbles, high nibble first. After the rising edge that samples the low nibble, `wr_en` is high for exactly one cycle, with `wr_addr` and `wr_data` holding that byte's address and value.
- R4: The first byte of a transaction is written at the start address. Each later byte is written one address lower, and address 0 wraps to 0x3FFF.
- R5: A header with the read flag set to 1 produces no write strobes and no sync pulse, whatever follows it.
- R6: Raising `cs_n` before a byte is complete discards the partial byte. The next low period starts with a fresh header.
- R7: On the first rising edge that samples `cs_n` high after a transaction, `sync_pulse` goes high for one cycle. This happens only if the header requested sync, the read flag was 0, and at least one byte was written.
- R8: No sync pulse is produced if the sync flag was 0, or if the transaction ended before its first data byte was complete.
- R9: `busy` is 1 from the first edge that samples `cs_n` low until the edge that samples `cs_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select that frames one transaction |
| nib_in | input | 4 | Nibble data bus |
| wr_en | output | 1 | One-cycle write strobe to the register bank |
| wr_addr | output | 14 | Byte address for the strobe |
| wr_data | output | 8 | Byte value for the strobe |
| sync_pulse | output | 1 | One-cycle sync event at the end of a qualifying transaction |
| busy | output | 1 | High while a transaction is open |

## Verification
The bench sends a multi-byte write that starts at address 1. This checks that the address steps down through 0 and wraps to 0x3FFF; a design that counted upward, or held the address, would log the wrong strobe addresses.

A transaction is aborted after only half a byte and is then followed by a new transaction. A design that kept the stale nibble, or stayed in the data phase, would write a spurious byte or take the new header as data.

Sync behaviour is tested three ways:
- a sync request that ends after the header, which must give no pulse;
- a read-flagged header, which must give neither strobes nor a pulse;
- a completed write with the sync flag set, which must give exactly one pulse, so a design that pulsed on every chip-select release would be caught.

Strobe counts also expose a strobe that stays high for more than one cycle.

// File: rtl/nwp_pkg.sv
package nwp_pkg;

  localparam int NWP_ADDR_W = 14;
  localparam int NWP_NIB_W  = 4;
  localparam int NWP_BYTE_W = 8;

  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

endpackage

// File: rtl/nwp_rst_sync.sv
module nwp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/nwp_framer.sv
module nwp_framer
  import nwp_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int HDR_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [NIB_W-1:0]  nib,
  output logic              active,
  output logic              hdr_fire,
  output logic [HDR_W-1:0]  hdr_word,
  output logic              byte_fire,
  output logic [BYTE_W-1:0] byte_word,
  output logic              end_fire
);

  localparam int HDR_NIBS  = HDR_W / NIB_W;
  localparam int BYTE_NIBS = BYTE_W / NIB_W;
  localparam int CNT_W     = (HDR_NIBS > 2) ? $clog2(HDR_NIBS) : 1;
  localparam int SHIFT_W   = HDR_W - NIB_W;
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_NIBS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_NIBS - 1);

  logic               active_q, active_d;
  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic               shift_en;
  logic               sample;
  logic               hdr_last;
  logic               byte_last;

  assign sample    = !cs_n;
  assign hdr_last  = (phase_q == PH_HDR)  && (cnt_q == HDR_LAST);
  assign byte_last = (phase_q == PH_DATA) && (cnt_q == BYTE_LAST);

  always_comb begin
    active_d = sample;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    shift_en = sample;
    shift_d  = {shift_q[SHIFT_W-NIB_W-1:0], nib};
    if (!sample) begin
      phase_d = PH_HDR;
      cnt_d   = '0;
    end else if (hdr_last || byte_last) begin
      phase_d = PH_DATA;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_HDR;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (shift_en) begin
      shift_q <= shift_d;
    end
  end

  assign active    = active_q;
  assign hdr_fire  = sample && hdr_last;
  assign byte_fire = sample && byte_last;
  assign hdr_word  = {shift_q, nib};
  assign byte_word = {shift_q[BYTE_W-NIB_W-1:0], nib};
  assign end_fire  = cs_n && active_q;

endmodule

// File: rtl/nwp_addr_gen.sv
module nwp_addr_gen #(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_fire,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              hdr_rd,
  input  logic              byte_fire,
  input  logic [BYTE_W-1:0] byte_word,
  output logic              byte_ok,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;
  logic              addr_en;
  logic              wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;

  assign byte_ok = byte_fire && !rd_q;

  always_comb begin
    addr_en = 1'b0;
    addr_d  = addr_q;
    rd_d    = rd_q;
    if (hdr_fire) begin
      addr_en = 1'b1;
      addr_d  = hdr_addr;
      rd_d    = hdr_rd;
    end else if (byte_ok) begin
      addr_en = 1'b1;
      addr_d  = addr_q - ADDR_W'(1);
    end
    wr_en_d = byte_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else if (addr_en) begin
      addr_q <= addr_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= wr_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (byte_ok) begin
      wr_addr_q <= addr_q;
      wr_data_q <= byte_word;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

endmodule

// File: rtl/nwp_sync_gen.sv
module nwp_sync_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic hdr_fire,
  input  logic hdr_rd,
  input  logic hdr_sync,
  input  logic byte_ok,
  input  logic end_fire,
  output logic sync_pulse
);

  logic req_q, req_d;
  logic seen_q, seen_d;
  logic pulse_q, pulse_d;

  always_comb begin
    req_d  = req_q;
    seen_d = seen_q;
    if (hdr_fire) begin
      req_d  = hdr_sync && !hdr_rd;
      seen_d = 1'b0;
    end else if (end_fire) begin
      req_d  = 1'b0;
      seen_d = 1'b0;
    end else if (byte_ok) begin
      seen_d = 1'b1;
    end
    pulse_d = end_fire && req_q && seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      seen_q  <= seen_d;
      pulse_q <= pulse_d;
    end
  end

  assign sync_pulse = pulse_q;

endmodule

// File: rtl/nibble_cfg_port.sv
module nibble_cfg_port
  import nwp_pkg::*;
#(
  parameter int ADDR_W = NWP_ADDR_W,
  parameter int NIB_W  = NWP_NIB_W,
  parameter int BYTE_W = NWP_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [NIB_W-1:0]  nib_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sync_pulse,
  output logic              busy
);

  localparam int HDR_W   = ADDR_W + 2;
  localparam int RD_BIT  = HDR_W - 1;
  localparam int SYN_BIT = HDR_W - 2;

  logic              rst_sync_n;
  logic              hdr_fire;
  logic [HDR_W-1:0]  hdr_word;
  logic              byte_fire;
  logic [BYTE_W-1:0] byte_word;
  logic              end_fire;
  logic              byte_ok;

  nwp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nwp_framer #(
    .NIB_W  (NIB_W),
    .HDR_W  (HDR_W),
    .BYTE_W (BYTE_W)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_n      (cs_n),
    .nib       (nib_in),
    .active    (busy),
    .hdr_fire  (hdr_fire),
    .hdr_word  (hdr_word),
    .byte_fire (byte_fire),
    .byte_word (byte_word),
    .end_fire  (end_fire)
  );

  nwp_addr_gen #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hdr_fire  (hdr_fire),
    .hdr_addr  (hdr_word[ADDR_W-1:0]),
    .hdr_rd    (hdr_word[RD_BIT]),
    .byte_fire (byte_fire),
    .byte_word (byte_word),
    .byte_ok   (byte_ok),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  nwp_sync_gen u_sync (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hdr_fire   (hdr_fire),
    .hdr_rd     (hdr_word[RD_BIT]),
    .hdr_sync   (hdr_word[SYN_BIT]),
    .byte_ok    (byte_ok),
    .end_fire   (end_fire),
    .sync_pulse (sync_pulse)
  );

endmodule

// File: rtl/nibble_cfg_port_chk.sv
module nibble_cfg_port_chk #(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              sync_pulse,
  input logic              busy
);

  // R3: a strobe never lasts more than one cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4: back-to-back bytes step the address down by one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en ##2 wr_en) |-> (wr_addr == $past(wr_addr, 2) - 1'b1));

  // R9: strobes only occur inside an open transaction
  p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R8: a byte cannot complete straight from idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !wr_en);

  // R7: sync pulse is one cycle and follows the close of a transaction
  p_sync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  p_sync_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> (!busy && $past(busy)));

  // R3: data bus holds its value when no strobe is issued
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (wr_en || $stable(wr_data)));

endmodule

bind nibble_cfg_port nibble_cfg_port_chk #(
  .ADDR_W (ADDR_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .sync_pulse (sync_pulse),
  .busy       (busy)
);

// File: tb/tb_nibble_cfg_port.sv
module tb_nibble_cfg_port;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_N      = 64;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic [3:0]  nib_in;
  logic        wr_en;
  logic [13:0] wr_addr;
  logic [7:0]  wr_data;
  logic        sync_pulse;
  logic        busy;

  int checks;
  int errors;
  int mon_cnt;
  int sync_cnt;
  logic [13:0] log_addr [LOG_N];
  logic [7:0]  log_data [LOG_N];

  nibble_cfg_port dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .nib_in     (nib_in),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sync_pulse (sync_pulse),
    .busy       (busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    mon_cnt  = 0;
    sync_cnt = 0;
  end

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (mon_cnt < LOG_N) begin
        log_addr[mon_cnt] = wr_addr;
        log_data[mon_cnt] = wr_data;
      end
      mon_cnt = mon_cnt + 1;
    end
    if (rst_n && sync_pulse) sync_cnt = sync_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_nib(input logic [3:0] n);
    @(negedge clk);
    cs_n   = 1'b0;
    nib_in = n;
    @(posedge clk);
  endtask

  task automatic end_txn();
    @(negedge clk);
    cs_n   = 1'b1;
    nib_in = 4'h0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_hdr(input logic rd, input logic sy, input logic [13:0] addr);
    logic [15:0] h;
    h = {rd, sy, addr};
    send_nib(h[15:12]);
    send_nib(h[11:8]);
    send_nib(h[7:4]);
    send_nib(h[3:0]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_nib(b[7:4]);
    send_nib(b[3:0]);
  endtask

  task automatic test_reset();
    rst_n  = 1'b0;
    cs_n   = 1'b1;
    nib_in = 4'h0;
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
    chk(sync_pulse == 1'b0, "R1 sync in reset", int'(sync_pulse), 0);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(wr_en == 1'b0 && sync_pulse == 1'b0 && busy == 1'b0, "R1 after release",
        int'({wr_en, sync_pulse, busy}), 0);
  endtask

  task automatic test_basic_write();
    int s0, y0;
    s0 = mon_cnt; y0 = sync_cnt;
    send_hdr(1'b0, 1'b0, 14'h1234);
    #1 chk(busy == 1'b1, "R9 busy during txn", int'(busy), 1);
    send_byte(8'hA5);
    send_byte(8'h3C);
    end_txn();
    chk(mon_cnt - s0 == 2, "R3 strobe count", mon_cnt - s0, 2);
    chk(log_addr[s0] == 14'h1234 && log_data[s0] == 8'hA5, "R2 first byte",
        int'({log_addr[s0], log_data[s0]}), int'({14'h1234, 8'hA5}));
    chk(log_addr[s0+1] == 14'h1233 && log_data[s0+1] == 8'h3C, "R4 second byte",
        int'({log_addr[s0+1], log_data[s0+1]}), int'({14'h1233, 8'h3C}));
    chk(sync_cnt == y0, "R8 no sync when flag clear", sync_cnt - y0, 0);
    chk(busy == 1'b0, "R9 busy after end", int'(busy), 0);
  endtask

  task automatic test_wrap_sync();
    int s0, y0;
    s0 = mon_cnt; y0 = sync_cnt;
    send_hdr(1'b0, 1'b1, 14'h0001);
    send_byte(8'h10);
    send_byte(8'h20);
    send_byte(8'h30);
    end_txn();
    chk(mon_cnt - s0 == 3, "R3 strobe count wrap", mon_cnt - s0, 3);
    chk(log_addr[s0] == 14'h0001, "R4 addr 1", int'(log_addr[s0]), 1);
    chk(log_addr[s0+1] == 14'h0000, "R4 addr 0", int'(log_addr[s0+1]), 0);
    chk(log_addr[s0+2] == 14'h3FFF && log_data[s0+2] == 8'h30, "R4 wrap",
        int'({log_addr[s0+2], log_data[s0+2]}), int'({14'h3FFF, 8'h30}));
    chk(sync_cnt - y0 == 1, "R7 one sync pulse", sync_cnt - y0, 1);
  endtask

  task automatic test_early_end();
    int s0, y0;
    s0 = mon_cnt; y0 = sync_cnt;
    send_hdr(1'b0, 1'b1, 14'h0055);
    send_nib(4'hE);
    end_txn();
    chk(mon_cnt == s0, "R6 partial byte dropped", mon_cnt - s0, 0);
    chk(sync_cnt == y0, "R8 no sync before first byte", sync_cnt - y0, 0);
  endtask

  task automatic test_read_flag();
    int s0, y0;
    s0 = mon_cnt; y0 = sync_cnt;
    send_hdr(1'b1, 1'b1, 14'h0200);
    send_byte(8'h77);
    send_byte(8'h88);
    end_txn();
    chk(mon_cnt == s0, "R5 no strobe on read", mon_cnt - s0, 0);
    chk(sync_cnt == y0, "R5 no sync on read", sync_cnt - y0, 0);
  endtask

  task automatic test_abort_restart();
    int s0;
    s0 = mon_cnt;
    send_hdr(1'b0, 1'b0, 14'h0100);
    send_byte(8'h11);
    send_nib(4'hF);
    end_txn();
    send_hdr(1'b0, 1'b0, 14'h0222);
    send_byte(8'h22);
    end_txn();
    chk(mon_cnt - s0 == 2, "R6 strobes around abort", mon_cnt - s0, 2);
    chk(log_addr[s0] == 14'h0100 && log_data[s0] == 8'h11, "R6 byte before abort",
        int'({log_addr[s0], log_data[s0]}), int'({14'h0100, 8'h11}));
    chk(log_addr[s0+1] == 14'h0222 && log_data[s0+1] == 8'h22, "R6 fresh header",
        int'({log_addr[s0+1], log_data[s0+1]}), int'({14'h0222, 8'h22}));
  endtask

  task automatic test_busy_edges();
    send_nib(4'h0);
    #1 chk(busy == 1'b1, "R9 busy after first nibble", int'(busy), 1);
    @(negedge clk);
    cs_n = 1'b1;
    @(posedge clk);
    #1 chk(busy == 1'b0, "R9 busy clears on cs high", int'(busy), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    test_reset();
    test_basic_write();
    test_wrap_sync();
    test_early_end();
    test_read_flag();
    test_abort_restart();
    test_busy_edges();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule